// File: doc/BRIEF.md
# High-Memory Bank Overlay Controller

This block steers CPU accesses to the top twelve kilobytes of a 16-bit, byte-wide address space ($D000-$FFFF), where switchable RAM overlays a fixed ROM. A four-bit control value picks the active arrangement. Software changes that value by touching any address in a sixteen-byte switch window at $C080-$C08F. A read and a write there have the same effect, and the data byte is ignored. The low address nibble of that access, with bit 2 forced to zero, becomes the new control value on the next clock edge.

For every access to $D000-$FFFF the block reports, in the same cycle, three things: whether a read must be served by ROM, whether a write may reach RAM, and whether RAM traffic goes to the auxiliary 64 KB bank. It also gives the physical RAM address. The $D000-$DFFF window has two 4 KB banks. One of them is stored at RAM offset $C000-$CFFF, below the window. Software can read two status bytes that reflect the control value. The memory arrays and the address mapping below $D000 belong to other blocks.

Top module: `hiBankCtrl`

## Requirements
- R1: When `busValid` is high and `busAddr` is in $C080-$C08F, for a read or a write, the control value takes `busAddr[3:0] & 4'b1011` at the next rising clock edge. An access with `busValid` low, or with an address outside that window, leaves the control value unchanged.
- R2: After reset the control value is 4'h2: reads of $D000-$FFFF come from ROM and writes there are dropped.
- R3: Control bits [1:0] select the read source for reads of $D000-$FFFF. `readFromRom` is 1 for codes 01 and 10, and 0 (RAM is read) for codes 00 and 11.
- R4: `ramWriteEn` is 1 for a valid write to $D000-$FFFF only when control bits [1:0] are 01 or 11. In every other mode such a write is dropped silently, with `ramWriteEn` held at 0.
- R5: Control bit 3 selects the $D000-$DFFF bank. When the bit is clear, `ramAddr` equals `busAddr`. When the bit is set, `ramAddr` is `busAddr` with bits [15:12] replaced by 4'hC. Addresses in $E000-$FFFF are never remapped.
- R6: `auxSelect` equals `auxLevel` for valid accesses to $D000-$FFFF.
- R7: A valid read of $C011 returns `statusData` 8'h80 when the control value is below 4, and 8'h00 otherwise.
- R8: A valid read of $C012 returns `statusData` 8'h00 when control bit 0 XOR bit 1 is 1 (ROM is read), and 8'h80 otherwise.
- R9: Outside $D000-$FFFF, `readFromRom`, `ramWriteEn` and `auxSelect` are 0 and `ramAddr` is 16'h0000. `statusData` is 8'h00 for every access other than a valid read of $C011 or $C012.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | CPU address |
| busValid | input | 1 | Access strobe for the current cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| auxLevel | input | 1 | Selects the auxiliary RAM bank for overlay RAM traffic |
| readFromRom | output | 1 | The current read of $D000-$FFFF is served by ROM |
| ramWriteEn | output | 1 | The current write of $D000-$FFFF reaches RAM |
| auxSelect | output | 1 | Overlay RAM traffic goes to the auxiliary bank |
| ramAddr | output | 16 | Physical RAM address for $D000-$FFFF accesses |
| statusData | output | 8 | Status byte for reads of $C011 and $C012 |

## Verification
The control register has no direct read path. After each of the sixteen window addresses is loaded, by a read and again by a write, its state can only be inferred from probe accesses. These probes are a write to the banked window, a write and a read in the unbanked region, and reads of both status bytes, with the auxiliary level at each value. The hardest case is proving that a stray access left the state alone. To do this, the bench first loads a state that the strays would visibly change. The strays are an address just above the window, one just below it, and an in-window address with the strobe low. The bench then checks through the probes that the old state is still in force.

// File: rtl/hiBankPkg.sv
package hiBankPkg;
  typedef enum logic [1:0] {
    MODE_RAM_RD    = 2'b00,
    MODE_ROM_RD_WR = 2'b01,
    MODE_ROM_RD    = 2'b10,
    MODE_RAM_RW    = 2'b11
  } bankMode_t;

  // strobe bundle from the window decoder to the datapath
  typedef struct packed {
    logic       load;
    logic [3:0] value;
  } ctlStrobe_t;
endpackage

// File: rtl/hiBankCtl.sv
module hiBankCtl
  import hiBankPkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     WIN_BASE = 16'hC080,
  parameter logic [3:0]      KEEP_MSK = 4'b1011
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  output ctlStrobe_t        strobe
);
  localparam int SPAN_LOG2 = 4;
  localparam logic [ADDR_W-SPAN_LOG2-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:SPAN_LOG2];

  logic inWindow;

  always_comb begin
    inWindow     = (busAddr[ADDR_W-1:SPAN_LOG2] == WIN_TAG);
    strobe.load  = busValid && inWindow;
    strobe.value = busAddr[SPAN_LOG2-1:0] & KEEP_MSK;
  end
endmodule

// File: rtl/hiBankStatus.sv
module hiBankStatus #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BANK_ADDR = 16'hC011,
  parameter logic [15:0] RDSRC_ADDR = 16'hC012
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [3:0]        ctlState,
  output logic [DATA_W-1:0] statusData
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic isRead;
  logic flagBit;

  always_comb begin
    isRead  = busValid && !busWrite;
    flagBit = 1'b0;
    if (isRead && busAddr == BANK_ADDR[ADDR_W-1:0])
      flagBit = (ctlState < 4'd4);
    else if (isRead && busAddr == RDSRC_ADDR[ADDR_W-1:0])
      flagBit = !(ctlState[0] ^ ctlState[1]);
    statusData = '0;
    statusData[FLAG_BIT] = flagBit;
  end

  // R9
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusData[FLAG_BIT-1:0] == '0);

  // R9
  status_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> statusData == '0);
endmodule

// File: rtl/hiBankDp.sv
module hiBankDp
  import hiBankPkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter logic [3:0] RST_STATE = 4'h2,
  parameter logic [3:0] BANK_NIB  = 4'hD,
  parameter logic [3:0] ALT_NIB   = 4'hC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              auxLevel,
  output logic [3:0]        ctlState,
  output logic              readFromRom,
  output logic              ramWriteEn,
  output logic              auxSelect,
  output logic [ADDR_W-1:0] ramAddr
);
  localparam int NIB_LO = ADDR_W - 4;

  bankMode_t  mode;
  logic       romRead;
  logic       writeOk;
  logic       bankAlt;
  logic       inHigh;
  logic       inBankWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctlState <= RST_STATE;
    else if (strobe.load) ctlState <= strobe.value;
  end

  always_comb begin
    mode      = bankMode_t'(ctlState[1:0]);
    romRead   = (mode == MODE_ROM_RD_WR) || (mode == MODE_ROM_RD);
    writeOk   = (mode == MODE_ROM_RD_WR) || (mode == MODE_RAM_RW);
    bankAlt   = ctlState[3];
    inHigh    = busValid && (busAddr[ADDR_W-1:NIB_LO] >= BANK_NIB);
    inBankWin = busAddr[ADDR_W-1:NIB_LO] == BANK_NIB;

    readFromRom = inHigh && !busWrite && romRead;
    ramWriteEn  = inHigh && busWrite && writeOk;
    auxSelect   = inHigh && auxLevel;
    ramAddr     = '0;
    if (inHigh) begin
      ramAddr = busAddr;
      if (inBankWin && bankAlt) ramAddr[ADDR_W-1:NIB_LO] = ALT_NIB;
    end
  end

  // R1
  state_bit2_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlState[2]);

  // R4
  write_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWriteEn |-> (busValid && busWrite));

  // R3
  rom_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    readFromRom |-> (busValid && !busWrite && !ramWriteEn));

  // R6
  aux_follows_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxSelect |-> auxLevel);

  // R5
  bank_never_d_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && bankAlt && inBankWin) |-> ramAddr[ADDR_W-1:NIB_LO] == ALT_NIB);

  // R9
  outside_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inHigh |-> (ramAddr == '0 && !auxSelect && !ramWriteEn && !readFromRom));
endmodule

// File: rtl/hiBankCtrl.sv
module hiBankCtrl
  import hiBankPkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] WIN_BASE = 16'hC080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              auxLevel,
  output logic              readFromRom,
  output logic              ramWriteEn,
  output logic              auxSelect,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] statusData
);
  ctlStrobe_t strobe;
  logic [3:0] ctlState;

  hiBankCtl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_ctl (
    .busAddr(busAddr), .busValid(busValid), .strobe(strobe)
  );

  hiBankDp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busValid(busValid), .busWrite(busWrite), .auxLevel(auxLevel),
    .ctlState(ctlState), .readFromRom(readFromRom), .ramWriteEn(ramWriteEn),
    .auxSelect(auxSelect), .ramAddr(ramAddr)
  );

  hiBankStatus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busValid(busValid),
    .busWrite(busWrite), .ctlState(ctlState), .statusData(statusData)
  );

  // R1
  window_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4])
      |=> ctlState == ($past(busAddr[3:0]) & 4'b1011));

  // R1
  hold_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busAddr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]) |=> $stable(ctlState));
endmodule

// File: tb/hiBankCtrl_tb.sv
module hiBankCtrl_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic        auxLevel = 1'b0;
  logic        readFromRom, ramWriteEn, auxSelect;
  logic [15:0] ramAddr;
  logic [7:0]  statusData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hiBankCtrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busValid(busValid),
    .busWrite(busWrite), .auxLevel(auxLevel), .readFromRom(readFromRom),
    .ramWriteEn(ramWriteEn), .auxSelect(auxSelect), .ramAddr(ramAddr),
    .statusData(statusData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample shortly after (away from the rising edge)
  task automatic drive(input logic [15:0] a, input logic w, input logic ax, input logic v = 1'b1);
    @(negedge clk);
    busAddr = a; busWrite = w; auxLevel = ax; busValid = v;
    #1;
  endtask

  // probe the state through the ports; s is the expected control value
  task automatic probe(input logic [3:0] s);
    logic romRd, wrOk;
    romRd = s[0] ^ s[1];
    wrOk  = s[0];
    for (int ax = 0; ax < 2; ax++) begin
      drive(16'hD123, 1'b1, ax[0]);
      check("R4 write D123", ramWriteEn, wrOk);
      check("R5 bank addr", ramAddr, s[3] ? 16'hC123 : 16'hD123);
      check("R6 aux", auxSelect, ax);
      drive(16'hE456, 1'b0, ax[0]);
      check("R3 read E456", readFromRom, romRd);
      check("R5 unbanked", ramAddr, 16'hE456);
      check("R6 aux read", auxSelect, ax);
    end
    drive(16'hFFF0, 1'b1, 1'b0);
    check("R4 write FFF0", ramWriteEn, wrOk);
    drive(16'hD800, 1'b0, 1'b0);
    check("R3 read D800", readFromRom, romRd);
    drive(16'hC011, 1'b0, 1'b0);
    check("R7 status", statusData, (s < 4) ? 8'h80 : 8'h00);
    drive(16'hC012, 1'b0, 1'b0);
    check("R8 status", statusData, romRd ? 8'h00 : 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state, seen while reset is held and after release
    drive(16'hD000, 1'b0, 1'b0);
    check("R2 rom at reset", readFromRom, 1);
    rstN = 1'b1;
    probe(4'h2);

    // R1 full sweep of the switch window, by read and by write
    for (int a = 0; a < 16; a++) begin
      for (int w = 0; w < 2; w++) begin
        drive(16'hC080 | 16'(a), w[0], 1'b0);
        probe(4'(a) & 4'b1011);
      end
    end

    // R1 stray accesses must not alter the state
    drive(16'hC083, 1'b0, 1'b0);
    drive(16'hC090, 1'b1, 1'b0);
    drive(16'hC07F, 1'b0, 1'b0);
    drive(16'hC08A, 1'b0, 1'b0, 1'b0);
    probe(4'h3);
    drive(16'hC08B, 1'b1, 1'b0);
    probe(4'hB);

    // R9 outside the overlay region
    drive(16'h8000, 1'b1, 1'b1);
    check("R9 outside wr", ramWriteEn, 0);
    check("R9 outside aux", auxSelect, 0);
    check("R9 outside addr", ramAddr, 0);
    drive(16'hCFFF, 1'b0, 1'b1);
    check("R9 outside rom", readFromRom, 0);
    drive(16'hC011, 1'b1, 1'b0);
    check("R9 status on write", statusData, 0);
    drive(16'hD000, 1'b0, 1'b1, 1'b0);
    check("R9 invalid aux", auxSelect, 0);

    @(negedge clk);
    busValid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule